// File: doc/BRIEF.md
# Serial Block-Error Resolver and Minimum Tracker

This block completes one step of a block-matching motion search. When the accumulation of absolute differences for one candidate block is finished, that total still exists as two redundant vectors: a sum vector and a carry vector. On a load pulse the block takes both vectors and the candidate's index. It then walks through the bits from the least significant one, one bit per clock. A single full adder with a carry flip-flop turns the redundant pair into the binary error value. In the same cycle, a second full adder compares each new bit with the matching bit of the smallest error stored so far.

After W cycles the final carry of the comparison decides the outcome. If the new error is strictly smaller, the block keeps it together with its index. Otherwise the stored pair stays. W is far shorter than the accumulation period of the next candidate, so one tracker can follow a continuous stream of candidates. A search-start clear resets the stored minimum and the index. After a clear, the first candidate is always accepted.

Top module: `sad_min_tracker`

## Requirements
- R1: After reset, min_o is all ones and best_o, busy_o, done_o and err_o are all zero.
- R2: The error of a candidate is (sum_i + carry_i) modulo 2^W, where W is the width of the vectors. When a candidate wins, min_o shows exactly this value.
- R3: The first candidate accepted after a clear or a reset always becomes the minimum. This holds even when its error is all ones.
- R4: Every later candidate replaces the stored minimum only when its error is strictly smaller. On a tie, or when the new error is larger, min_o and best_o keep their values.
- R5: A load accepted at a clock edge raises busy_o for exactly W cycles. In the cycle after the last busy cycle, busy_o is low and done_o is high for exactly one cycle.
- R6: A load that arrives while busy_o is high has no effect on the running comparison, min_o, best_o or the busy length. It sets err_o, and err_o stays high until the next clear or reset.
- R7: clear_i (search start) has priority over load_i. At the next edge it sets min_o to all ones and best_o and err_o to zero. It also cancels any comparison in progress: busy_o goes low and no done_o pulse follows.
- R8: Outside a clear, min_o never increases.
- R9: A load is accepted in the same cycle that done_o is high. Candidates can therefore follow each other with no gap cycle and without setting err_o.
- R10: best_o changes only together with a done_o pulse or a clear, and it always holds the index that was loaded with the value shown on min_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Search start: resets the stored minimum, the index and the error flag |
| load_i | input | 1 | Takes one finished candidate |
| sum_i | input | W | Sum vector of the redundant accumulation |
| carry_i | input | W | Carry vector of the redundant accumulation, already weighted to line up with sum_i |
| idx_i | input | IDX_W | Index of the candidate block |
| min_o | output | W | Smallest error found since the last search start |
| best_o | output | IDX_W | Index that belongs to min_o |
| busy_o | output | 1 | Resolution and comparison in progress |
| done_o | output | 1 | One-cycle pulse when a comparison has finished |
| err_o | output | 1 | Sticky flag: a load arrived while busy_o was high |

## Verification
The bound checker watches the timing contract on every cycle. It checks that each busy window lasts exactly W cycles, that done_o only follows a busy window, that err_o is raised and held, and that min_o never rises between clears. It also checks that best_o moves only with done_o and that a clear leaves the clean state. Whether each resolved value is the right sum of the two vectors, and whether ties, wrap-around and a first candidate of all ones are handled correctly, depends on the data. Only the bench's candidate sequences against its own reference model show these.

// File: rtl/sad_min_pkg.sv
package sad_min_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   function automatic logic fa_sum(input logic a, input logic b, input logic c);
      return a ^ b ^ c;
   endfunction

   function automatic logic fa_carry(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/sad_min_fa.sv
module sad_min_fa #(
   parameter int FA_IMPL = 0
) (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   import sad_min_pkg::*;

   generate
      if (FA_IMPL == 0) begin : g_gates
         assign s_o = fa_sum(a_i, b_i, c_i);
         assign c_o = fa_carry(a_i, b_i, c_i);
      end else begin : g_arith
         logic [1:0] tot;
         assign tot = {1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i};
         assign s_o = tot[0];
         assign c_o = tot[1];
      end
   endgenerate

endmodule

// File: rtl/sad_min_resolver.sv
module sad_min_resolver #(
   parameter int W       = 16,
   parameter int FA_IMPL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         step_i,
   input  logic [W-1:0] sum_i,
   input  logic [W-1:0] carry_i,
   output logic         bit_o,
   output logic [W-1:0] value_o
);
   logic [W-1:0] sum_sh;
   logic [W-1:0] cy_sh;
   logic [W-1:0] res_sh;
   logic         c_q;
   logic         s_w;
   logic         c_w;

   sad_min_fa #(.FA_IMPL(FA_IMPL)) u_fa (
      .a_i (sum_sh[0]),
      .b_i (cy_sh[0]),
      .c_i (c_q),
      .s_o (s_w),
      .c_o (c_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_sh <= '0;
         cy_sh  <= '0;
         res_sh <= '0;
         c_q    <= 1'b0;
      end else if (start_i) begin
         sum_sh <= sum_i;
         cy_sh  <= carry_i;
         c_q    <= 1'b0;
      end else if (step_i) begin
         sum_sh <= sum_sh >> 1;
         cy_sh  <= cy_sh >> 1;
         res_sh <= {s_w, res_sh[W-1:1]};
         c_q    <= c_w;
      end
   end

   assign bit_o   = s_w;
   assign value_o = {s_w, res_sh[W-1:1]};

endmodule

// File: rtl/sad_min_cmp.sv
module sad_min_cmp #(
   parameter int FA_IMPL = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic step_i,
   input  logic new_bit_i,
   input  logic old_bit_i,
   output logic win_o
);
   // stored + ~new with carry-in 0 gives stored - new - 1.
   // A carry out (no borrow) means stored > new, i.e. new strictly smaller.
   logic c_q;
   logic s_unused;
   logic c_w;

   sad_min_fa #(.FA_IMPL(FA_IMPL)) u_fa (
      .a_i (old_bit_i),
      .b_i (~new_bit_i),
      .c_i (c_q),
      .s_o (s_unused),
      .c_o (c_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       c_q <= 1'b0;
      else if (start_i) c_q <= 1'b0;
      else if (step_i)  c_q <= c_w;
   end

   assign win_o = c_w;

endmodule

// File: rtl/sad_min_ctrl.sv
module sad_min_ctrl #(
   parameter int W  = 16,
   parameter int CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          load_i,
   output logic          start_o,
   output logic          step_o,
   output logic          last_o,
   output logic [CW-1:0] bit_idx_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o
);
   import sad_min_pkg::*;

   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   phase_e        ph_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic          err_q;
   logic          run_w;

   assign run_w   = (ph_q == PH_RUN);
   assign start_o = load_i & ~run_w & ~clear_i;
   assign step_o  = run_w & ~clear_i;
   assign last_o  = step_o & (cnt_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (clear_i) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= last_o;
         if (load_i && run_w) err_q <= 1'b1;
         if (start_o) begin
            ph_q  <= PH_RUN;
            cnt_q <= '0;
         end else if (last_o) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
         end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign bit_idx_o = cnt_q;
   assign busy_o    = run_w;
   assign done_o    = done_q;
   assign err_o     = err_q;

endmodule

// File: rtl/sad_min_tracker.sv
module sad_min_tracker #(
   parameter int W       = 16,
   parameter int IDX_W   = 8,
   parameter int FA_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic [W-1:0]     sum_i,
   input  logic [W-1:0]     carry_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [W-1:0]     min_o,
   output logic [IDX_W-1:0] best_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int CW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("sad_min_tracker: W must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("sad_min_tracker: IDX_W must be at least 1");
      end
      if (FA_IMPL < 0 || FA_IMPL > 1) begin : g_bad_fa
         $error("sad_min_tracker: FA_IMPL must be 0 or 1");
      end
   endgenerate

   logic          start_w;
   logic          step_w;
   logic          last_w;
   logic [CW-1:0] bit_idx_w;
   logic          new_bit_w;
   logic [W-1:0]  new_val_w;
   logic          win_w;
   logic          take_w;

   logic [W-1:0]     min_q;
   logic [IDX_W-1:0] best_q;
   logic [IDX_W-1:0] idx_q;
   logic             have_q;

   sad_min_ctrl #(.W(W), .CW(CW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_i),
      .load_i    (load_i),
      .start_o   (start_w),
      .step_o    (step_w),
      .last_o    (last_w),
      .bit_idx_o (bit_idx_w),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .err_o     (err_o)
   );

   sad_min_resolver #(.W(W), .FA_IMPL(FA_IMPL)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_w),
      .step_i  (step_w),
      .sum_i   (sum_i),
      .carry_i (carry_i),
      .bit_o   (new_bit_w),
      .value_o (new_val_w)
   );

   sad_min_cmp #(.FA_IMPL(FA_IMPL)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_w),
      .step_i    (step_w),
      .new_bit_i (new_bit_w),
      .old_bit_i (min_q[bit_idx_w]),
      .win_o     (win_w)
   );

   assign take_w = last_w & (~have_q | win_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q  <= '1;
         best_q <= '0;
         idx_q  <= '0;
         have_q <= 1'b0;
      end else if (clear_i) begin
         min_q  <= '1;
         best_q <= '0;
         have_q <= 1'b0;
      end else begin
         if (start_w) idx_q <= idx_i;
         if (last_w)  have_q <= 1'b1;
         if (take_w) begin
            min_q  <= new_val_w;
            best_q <= idx_q;
         end
      end
   end

   assign min_o  = min_q;
   assign best_o = best_q;

endmodule

// File: rtl/sad_min_tracker_chk.sv
module sad_min_tracker_chk #(
   parameter int W     = 16,
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_i,
   input logic             load_i,
   input logic [W-1:0]     min_o,
   input logic [IDX_W-1:0] best_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o
);
   localparam int KW = $clog2(W) + 2;

   logic [KW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_cnt < KW'(W)));

   a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(busy_o) && !$past(clear_i)) |-> ($past(run_cnt) == KW'(W - 1)));

   a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   a_r6_load_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && load_i && !clear_i) |=> err_o);

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clear_i) |=> err_o);

   a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (min_o == '1 && best_o == '0 && !busy_o && !done_o && !err_o));

   a_r8_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (min_o <= $past(min_o)));

   a_r10_best_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ($stable(best_o) || done_o));

endmodule

bind sad_min_tracker sad_min_tracker_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clear_i (clear_i),
   .load_i  (load_i),
   .min_o   (min_o),
   .best_o  (best_o),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .err_o   (err_o)
);

// File: tb/sad_min_tracker_tb.sv
`timescale 1ns/1ps
module sad_min_tracker_tb;
   localparam int W  = 16;
   localparam int IW = 8;
   localparam int NV = 7;

   typedef struct packed {
      logic [W-1:0]  s;
      logic [W-1:0]  c;
      logic [IW-1:0] id;
      logic          win;
   } vec_t;

   // stimulus and expected outcome (win = candidate must replace the minimum)
   localparam vec_t VEC [NV] = '{
      '{16'h1000, 16'h0234, 8'd1, 1'b1},   // first after clear -> 0x1234
      '{16'h00FF, 16'h0001, 8'd2, 1'b1},   // 0x0100 smaller
      '{16'h0080, 16'h0080, 8'd3, 1'b0},   // 0x0100 tie, keep idx 2
      '{16'hFFFF, 16'h0002, 8'd4, 1'b1},   // wraps to 0x0001
      '{16'h0001, 16'h0001, 8'd5, 1'b0},   // 0x0002 larger
      '{16'h0000, 16'h0000, 8'd6, 1'b1},   // zero
      '{16'h5555, 16'hAAAA, 8'd7, 1'b0}    // 0xFFFF larger
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic          load = 1'b0;
   logic [W-1:0]  sum_v = '0;
   logic [W-1:0]  cy_v = '0;
   logic [IW-1:0] idx_v = '0;
   logic [W-1:0]  min_o;
   logic [IW-1:0] best_o;
   logic          busy_o, done_o, err_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   sad_min_tracker #(.W(W), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .load_i(load),
      .sum_i(sum_v), .carry_i(cy_v), .idx_i(idx_v),
      .min_o(min_o), .best_o(best_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
   endtask

   // drive one load cycle; returns at the negedge after the capturing edge
   task automatic start_load(input logic [W-1:0] s, input logic [W-1:0] c, input logic [IW-1:0] id);
      @(negedge clk);
      sum_v = s; cy_v = c; idx_v = id; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (busy_o === 1'b1 && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      int n2;
      logic [W-1:0]  ref_min;
      logic [IW-1:0] ref_best;
      logic [W-1:0]  val;
      logic          seen;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 min", 32'(min_o), 32'hFFFF);
      chk("R1 best", 32'(best_o), 32'h0);
      chk("R1 busy", 32'(busy_o), 32'h0);
      chk("R1 done", 32'(done_o), 32'h0);
      chk("R1 err", 32'(err_o), 32'h0);

      pulse_clear();
      ref_min = '1; ref_best = '0;

      // vector table walk: R2 R4 R5 R10
      for (int i = 0; i < NV; i++) begin
         start_load(VEC[i].s, VEC[i].c, VEC[i].id);
         chk("R5 busy raised", 32'(busy_o), 32'h1);
         wait_done(n);
         chk("R5 busy length", 32'(n), 32'(W));
         chk("R5 done pulse", 32'(done_o), 32'h1);
         val = VEC[i].s + VEC[i].c;
         if (VEC[i].win) begin
            ref_min = val;
            ref_best = VEC[i].id;
         end
         chk("R2/R4 min", 32'(min_o), 32'(ref_min));
         chk("R10 best", 32'(best_o), 32'(ref_best));
         @(negedge clk);
         chk("R5 done single", 32'(done_o), 32'h0);
      end
      chk("R8 min kept at zero", 32'(min_o), 32'h0);

      // R3: first candidate all ones is still accepted
      pulse_clear();
      chk("R7 clear min", 32'(min_o), 32'hFFFF);
      chk("R7 clear best", 32'(best_o), 32'h0);
      start_load(16'hFFFF, 16'h0000, 8'd9);
      wait_done(n);
      chk("R3 first all-ones min", 32'(min_o), 32'hFFFF);
      chk("R3 first all-ones best", 32'(best_o), 32'd9);

      // R6: load while busy ignored, err set
      pulse_clear();
      start_load(16'h0100, 16'h0000, 8'd10);
      n = 0;
      repeat (3) begin n++; @(negedge clk); end
      sum_v = 16'h0000; cy_v = 16'h0000; idx_v = 8'd11; load = 1'b1;
      n++;
      @(negedge clk);
      load = 1'b0;
      chk("R6 err set", 32'(err_o), 32'h1);
      wait_done(n2);
      chk("R6 busy length unchanged", 32'(n + n2), 32'(W));
      chk("R6 min unaffected", 32'(min_o), 32'h0100);
      chk("R6 best unaffected", 32'(best_o), 32'd10);
      repeat (5) @(negedge clk);
      chk("R6 no second run", 32'(busy_o), 32'h0);
      chk("R6 err sticky", 32'(err_o), 32'h1);
      pulse_clear();
      chk("R7 clear err", 32'(err_o), 32'h0);

      // R9: back-to-back load in the done cycle
      start_load(16'h0050, 16'h0000, 8'd12);
      wait_done(n);
      chk("R9 done before reload", 32'(done_o), 32'h1);
      sum_v = 16'h0040; cy_v = 16'h0000; idx_v = 8'd13; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk("R9 reload accepted", 32'(busy_o), 32'h1);
      wait_done(n);
      chk("R9 busy length", 32'(n), 32'(W));
      chk("R9 min", 32'(min_o), 32'h0040);
      chk("R9 best", 32'(best_o), 32'd13);
      chk("R9 no error", 32'(err_o), 32'h0);

      // R7: clear aborts a running comparison
      start_load(16'h0001, 16'h0000, 8'd14);
      repeat (4) @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      chk("R7 abort busy", 32'(busy_o), 32'h0);
      chk("R7 abort min", 32'(min_o), 32'hFFFF);
      chk("R7 abort best", 32'(best_o), 32'h0);
      seen = 1'b0;
      repeat (20) begin
         if (done_o === 1'b1 || busy_o === 1'b1) seen = 1'b1;
         @(negedge clk);
      end
      chk("R7 no done after abort", 32'(seen), 32'h0);
      chk("R7 min still cleared", 32'(min_o), 32'hFFFF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule